// File: doc/BRIEF.md
# Pixel clock program word calculator

This block turns a requested pixel clock period, given in picoseconds, into the 13-bit program word that a frequency synthesizer expects. It first derives the target frequency in units of 10 kHz and rejects targets outside the range the synthesizer can produce. It then raises low targets into the oscillator's working band by repeated doubling, with a matching power-of-two post-divider. The doubled frequency is scaled by the ratio of the reference divider to the reference frequency and rounded, and the result is packed with a post-divider code and fixed stop bits.

A request is taken on a valid/ready handshake, and one request is in flight at a time. The result appears as a held response: a program word, the post-divider value (1, 2, 4 or 8) and an error flag. All three divisions run one after another on a single shared restoring divider, so a result takes roughly a hundred cycles. Serial shifting of the word into the synthesizer is handled elsewhere.

Top module: `pclk_word_calc`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A request with period 0 is answered with `out_err`=1, `out_word`=0 and `out_pdiv`=0, and `out_valid` rises in the cycle right after the accepting edge.
- R3: The target frequency is f = floor(100000000 / period). If f > 15938 the response has `out_err`=1, `out_word`=0 and `out_pdiv`=0.
- R4: If f < 1000 the response has `out_err`=1, `out_word`=0 and `out_pdiv`=0. f = 1000 and f = 15938 are both accepted.
- R5: While f < 8000, f is doubled and the post-divider, which starts at 1, is doubled. `out_pdiv` reports the final post-divider as the value 1, 2, 4 or 8.
- R6: With the doubled f, count = floor((floor(46000*f / 1432) + 500) / 1000). Bits 8:0 of `out_word` hold count - 257.
- R7: Bits 10:9 of `out_word` hold the post-divider code: 3 for /1, 2 for /2, 1 for /4 and 0 for /8.
- R8: Bits 12:11 of every non-error `out_word` are both 1 (stop bits), and the word is 13 bits wide.
- R9: `out_valid`, `out_word`, `out_pdiv` and `out_err` hold steady until `out_ready` is high at a clock edge, and `in_ready` is 0 from acceptance until the response is taken.
- R10: The post-divider state is cleared for each request, so a response depends only on its own period, even right after an error or a /8 result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to take a request |
| in_period | input | 32 | Requested pixel clock period in picoseconds |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response |
| out_word | output | 13 | Synthesizer program word, 0 on error |
| out_pdiv | output | 4 | Post-divider value 1, 2, 4 or 8, 0 on error |
| out_err | output | 1 | Requested period out of range |

## Verification
The bench tests periods right at the frequency limits (f = 15938 and f = 1000 accepted, 15941 and 999 rejected). A design with an off-by-one comparison would accept or reject one of these wrongly. It uses the zero period, where a design that starts the divider anyway would hang or return rubbish instead of an immediate error. It covers one period for each doubling depth, where a wrong loop bound or code mapping shows up as a wrong bits 10:9 field or a wrong `out_pdiv`. It also covers an exact-band target whose rounded count is exactly 257, where dropping the rounding term would make the low field wrap. Finally, it holds `out_ready` low to catch outputs that drift, and sends an in-range request after a /8 result and after an error to catch stale post-divider state.

// File: rtl/pclk_word_pkg.sv
package pclk_word_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIV_FREQ,
      ST_RANGE,
      ST_NORM,
      ST_DIV_SCALE,
      ST_DIV_ROUND,
      ST_DONE
   } calc_state_t;

   localparam int SHIFT_W = 2;
   localparam int PDIV_W  = 1 << SHIFT_W;

endpackage

// File: rtl/pclk_serial_div.sv
module pclk_serial_div #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         done,
   output logic [W-1:0] quotient
);
   localparam int CNT_W = $clog2(W + 1);

   logic [W-1:0]     rem_q;
   logic [W-1:0]     dvs_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic [W:0]       trial;
   logic [W:0]       diff;
   logic             fits;

   assign trial = {rem_q, quotient[W-1]};
   assign diff  = trial - {1'b0, dvs_q};
   assign fits  = (trial >= {1'b0, dvs_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q    <= '0;
         dvs_q    <= '0;
         quotient <= '0;
         cnt_q    <= '0;
         busy_q   <= 1'b0;
         done     <= 1'b0;
      end else if (start) begin
         rem_q    <= '0;
         dvs_q    <= divisor;
         quotient <= dividend;
         cnt_q    <= CNT_W'(W);
         busy_q   <= 1'b1;
         done     <= 1'b0;
      end else if (busy_q) begin
         rem_q    <= fits ? diff[W-1:0] : trial[W-1:0];
         quotient <= {quotient[W-2:0], fits};
         cnt_q    <= cnt_q - 1'b1;
         if (cnt_q == CNT_W'(1)) begin
            busy_q <= 1'b0;
            done   <= 1'b1;
         end
      end else begin
         done <= 1'b0;
      end
   end

endmodule

// File: rtl/pclk_word_pack.sv
module pclk_word_pack
   import pclk_word_pkg::*;
#(
   parameter int DIV_W     = 32,
   parameter int WORD_W    = 13,
   parameter int OFFSET    = 257,
   parameter int CODE_LSB  = 9,
   parameter int STOP_BITS = 'h1800
) (
   input  logic [DIV_W-1:0]   count,
   input  logic [SHIFT_W-1:0] shift,
   output logic [WORD_W-1:0]  word
);
   logic [DIV_W-1:0] low;
   logic [DIV_W-1:0] code_field;
   logic [DIV_W-1:0] full;

   assign low        = count - DIV_W'(OFFSET);
   assign code_field = DIV_W'(~shift) << CODE_LSB;
   assign full       = low | code_field | DIV_W'(STOP_BITS);
   assign word       = full[WORD_W-1:0];

endmodule

// File: rtl/pclk_word_calc.sv
module pclk_word_calc
   import pclk_word_pkg::*;
#(
   parameter int PERIOD_W  = 32,
   parameter int DIV_W     = 32,
   parameter int WORD_W    = 13,
   parameter int NUMERATOR = 100000000,
   parameter int F_MAX     = 15938,
   parameter int F_MIN     = 1000,
   parameter int F_LOW     = 8000,
   parameter int REF_DIV   = 46,
   parameter int REF_FREQ  = 1432,
   parameter int SCALE     = 1000,
   parameter int OFFSET    = 257,
   parameter int CODE_LSB  = 9,
   parameter int STOP_BITS = 'h1800
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [PERIOD_W-1:0] in_period,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [WORD_W-1:0]   out_word,
   output logic [PDIV_W-1:0]   out_pdiv,
   output logic                out_err
);
   localparam logic [DIV_W-1:0] NUM_V   = DIV_W'(NUMERATOR);
   localparam logic [DIV_W-1:0] FMAX_V  = DIV_W'(F_MAX);
   localparam logic [DIV_W-1:0] FMIN_V  = DIV_W'(F_MIN);
   localparam logic [DIV_W-1:0] FLOW_V  = DIV_W'(F_LOW);
   localparam logic [DIV_W-1:0] MULT_V  = DIV_W'(REF_DIV * SCALE);
   localparam logic [DIV_W-1:0] REF_V   = DIV_W'(REF_FREQ);
   localparam logic [DIV_W-1:0] SCALE_V = DIV_W'(SCALE);
   localparam logic [DIV_W-1:0] HALF_V  = DIV_W'(SCALE / 2);

   if (PERIOD_W > DIV_W) begin : g_bad_period_w
      $error("period width exceeds divider width");
   end
   if (F_MIN * (1 << (PDIV_W - 1)) < F_LOW) begin : g_bad_band
      $error("post-divider range cannot lift F_MIN to F_LOW");
   end
   if ((64'(REF_DIV) * 64'(SCALE) * 64'(2 * F_LOW)) >> DIV_W != 64'd0) begin : g_bad_scale
      $error("scaled frequency overflows the divider width");
   end
   if (WORD_W <= CODE_LSB + SHIFT_W) begin : g_bad_word
      $error("word too narrow for code field");
   end

   calc_state_t          state_q;
   logic [DIV_W-1:0]     freq_q;
   logic [SHIFT_W-1:0]   shift_q;
   logic                 div_start_q;
   logic [DIV_W-1:0]     dvd_q;
   logic [DIV_W-1:0]     dvs_q;
   logic                 div_done;
   logic [DIV_W-1:0]     div_quo;
   logic [WORD_W-1:0]    packed_word;

   pclk_serial_div #(.W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (div_start_q),
      .dividend (dvd_q),
      .divisor  (dvs_q),
      .done     (div_done),
      .quotient (div_quo)
   );

   pclk_word_pack #(
      .DIV_W     (DIV_W),
      .WORD_W    (WORD_W),
      .OFFSET    (OFFSET),
      .CODE_LSB  (CODE_LSB),
      .STOP_BITS (STOP_BITS)
   ) u_pack (
      .count (div_quo),
      .shift (shift_q),
      .word  (packed_word)
   );

   assign in_ready  = (state_q == ST_IDLE);
   assign out_valid = (state_q == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         freq_q      <= '0;
         shift_q     <= '0;
         div_start_q <= 1'b0;
         dvd_q       <= '0;
         dvs_q       <= '0;
         out_word    <= '0;
         out_pdiv    <= '0;
         out_err     <= 1'b0;
      end else begin
         div_start_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (in_valid) begin
                  shift_q <= '0;
                  if (in_period == '0) begin
                     out_err  <= 1'b1;
                     out_word <= '0;
                     out_pdiv <= '0;
                     state_q  <= ST_DONE;
                  end else begin
                     dvd_q       <= NUM_V;
                     dvs_q       <= DIV_W'(in_period);
                     div_start_q <= 1'b1;
                     state_q     <= ST_DIV_FREQ;
                  end
               end
            end
            ST_DIV_FREQ: begin
               if (div_done) begin
                  freq_q  <= div_quo;
                  state_q <= ST_RANGE;
               end
            end
            ST_RANGE: begin
               if (freq_q > FMAX_V || freq_q < FMIN_V) begin
                  out_err  <= 1'b1;
                  out_word <= '0;
                  out_pdiv <= '0;
                  state_q  <= ST_DONE;
               end else begin
                  state_q <= ST_NORM;
               end
            end
            ST_NORM: begin
               if (freq_q < FLOW_V) begin
                  freq_q  <= freq_q << 1;
                  shift_q <= shift_q + 1'b1;
               end else begin
                  dvd_q       <= freq_q * MULT_V;
                  dvs_q       <= REF_V;
                  div_start_q <= 1'b1;
                  state_q     <= ST_DIV_SCALE;
               end
            end
            ST_DIV_SCALE: begin
               if (div_done) begin
                  dvd_q       <= div_quo + HALF_V;
                  dvs_q       <= SCALE_V;
                  div_start_q <= 1'b1;
                  state_q     <= ST_DIV_ROUND;
               end
            end
            ST_DIV_ROUND: begin
               if (div_done) begin
                  out_err  <= 1'b0;
                  out_word <= packed_word;
                  out_pdiv <= PDIV_W'(1) << shift_q;
                  state_q  <= ST_DONE;
               end
            end
            ST_DONE: begin
               if (out_ready) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pclk_word_calc_chk.sv
module pclk_word_calc_chk #(
   parameter int PERIOD_W  = 32,
   parameter int WORD_W    = 13,
   parameter int PDIV_W    = 4,
   parameter int CODE_LSB  = 9,
   parameter int STOP_BITS = 'h1800
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_ready,
   input logic [PERIOD_W-1:0] in_period,
   input logic                out_valid,
   input logic                out_ready,
   input logic [WORD_W-1:0]   out_word,
   input logic [PDIV_W-1:0]   out_pdiv,
   input logic                out_err
);
   localparam logic [WORD_W-1:0] STOP_V = WORD_W'(STOP_BITS);

   logic [1:0] code;
   assign code = out_word[CODE_LSB +: 2];

   AST_ZERO_PERIOD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_period == '0 |=> out_valid && out_err) // R2
      else $error("zero period not answered with error");

   AST_ERR_CLEARS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_err |-> out_word == '0 && out_pdiv == '0) // R3
      else $error("error response carries data");

   AST_CODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_err |->
         (out_pdiv == PDIV_W'(1) && code == 2'd3) ||
         (out_pdiv == PDIV_W'(2) && code == 2'd2) ||
         (out_pdiv == PDIV_W'(4) && code == 2'd1) ||
         (out_pdiv == PDIV_W'(8) && code == 2'd0)) // R7
      else $error("post-divider code mismatch");

   AST_STOP_BITS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_err |-> (out_word & STOP_V) == STOP_V) // R8
      else $error("stop bits missing");

   AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_word)
         && $stable(out_pdiv) && $stable(out_err)) // R9
      else $error("response changed before acceptance");

   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready) // R9
      else $error("ready while response pending");

endmodule

bind pclk_word_calc pclk_word_calc_chk #(
   .PERIOD_W  (PERIOD_W),
   .WORD_W    (WORD_W),
   .PDIV_W    (pclk_word_pkg::PDIV_W),
   .CODE_LSB  (CODE_LSB),
   .STOP_BITS (STOP_BITS)
) u_chk (.*);

// File: tb/pclk_word_calc_bench.sv
module pclk_word_calc_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_period = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [12:0] out_word;
   logic [3:0]  out_pdiv;
   logic        out_err;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   logic [12:0] got_word;
   logic [3:0]  got_pdiv;
   logic        got_err;
   int          got_wait;

   always #5 clk = ~clk;

   pclk_word_calc u_pclk_word_calc (
      .clk (clk), .rst_n (rst_n),
      .in_valid (in_valid), .in_ready (in_ready), .in_period (in_period),
      .out_valid (out_valid), .out_ready (out_ready),
      .out_word (out_word), .out_pdiv (out_pdiv), .out_err (out_err)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Reference from the requirements (R3..R8)
   task automatic model(input longint p, output logic [12:0] w, output logic [3:0] pd,
                        output logic e);
      longint f, t, c, code, full;
      int d;
      w = '0; pd = '0; e = 1'b1;
      if (p == 0) return;
      f = 100000000 / p;
      if (f > 15938 || f < 1000) return;
      d = 1;
      while (f < 8000) begin f = f * 2; d = d * 2; end
      t = (46000 * f) / 1432;
      c = (t + 500) / 1000;
      code = (d == 1) ? 'h600 : (d == 2) ? 'h400 : (d == 4) ? 'h200 : 0;
      full = (c - 257) | code | 'h1800;
      w = full[12:0]; pd = 4'(d); e = 1'b0;
   endtask

   task automatic run_req(input logic [31:0] p, input int hold);
      @(negedge clk);
      in_valid = 1'b1; in_period = p;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      got_wait = 0;
      while (!out_valid && got_wait < 2000) begin @(negedge clk); got_wait++; end
      got_word = out_word; got_pdiv = out_pdiv; got_err = out_err;
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         check(out_valid && out_word == got_word && out_pdiv == got_pdiv
               && out_err == got_err, "R9 hold", out_word, got_word);
         check(!in_ready, "R9 in_ready low", in_ready, 0);
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      check(!out_valid, "R9 release", out_valid, 0);
   endtask

   task automatic req_vs_model(input logic [31:0] p, input string tag);
      logic [12:0] ew; logic [3:0] ep; logic ee;
      model(p, ew, ep, ee);
      run_req(p, 0);
      check(got_err == ee, {tag, " err"}, got_err, ee);
      check(got_word == ew, {tag, " word"}, got_word, ew);
      check(got_pdiv == ep, {tag, " pdiv"}, got_pdiv, ep);
   endtask

   task automatic t_reset;
      check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
      check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
   endtask

   task automatic t_zero_period;
      run_req(32'd0, 0);
      check(got_wait == 0, "R2 latency", got_wait, 0);
      check(got_err && got_word == 0 && got_pdiv == 0, "R2 error response", got_word, 0);
   endtask

   task automatic t_range_edges;
      req_vs_model(32'd6273, "R3 above max");
      check(got_err == 1'b1, "R3 f=15941 rejected", got_err, 1);
      req_vs_model(32'd6274, "R3 at max");
      check(got_word == 13'h1EFF, "R6 f=15938 word", got_word, 'h1EFF);
      req_vs_model(32'd100001, "R4 below min");
      check(got_err == 1'b1, "R4 f=999 rejected", got_err, 1);
      req_vs_model(32'd100000, "R4 at min");
      check(got_word == 13'h1800 && got_pdiv == 4'd8, "R5 f=1000 div8", got_word, 'h1800);
   endtask

   task automatic t_post_div;
      req_vs_model(32'd12500, "R7 div1");
      check(got_word == 13'h1E00, "R6 count 257 rounds", got_word, 'h1E00);
      req_vs_model(32'd20000, "R5 div2");
      check(got_word == 13'h1C40, "R6 f=10000 scaled", got_word, 'h1C40);
      req_vs_model(32'd39722, "R5 div4");
      req_vs_model(32'd12501, "R5 doubled past band");
      req_vs_model(32'd10000, "R8 div1 mid");
      req_vs_model(32'd71000, "R7 div8");
   endtask

   task automatic t_hold;
      logic [12:0] ew; logic [3:0] ep; logic ee;
      model(32'd15000, ew, ep, ee);
      run_req(32'd15000, 6);
      check(got_word == ew && got_pdiv == ep && !got_err, "R9 held value", got_word, ew);
   endtask

   task automatic t_back_to_back;
      req_vs_model(32'd100000, "R10 div8 first");
      req_vs_model(32'd12500, "R10 after div8");
      req_vs_model(32'd0, "R10 error first");
      req_vs_model(32'd25000, "R10 after error");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_zero_period;
      t_range_edges;
      t_post_div;
      t_hold;
      t_back_to_back;
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule